// File: doc/BRIEF.md
# Byte FIFO Pair with Receive Threshold Flag

This block places two byte queues between a serial line engine and a byte-wide register port. Bytes that the engine receives enter the receive queue with a few error bits stored beside each byte. Software takes them out by reading the data register. Bytes that software writes to the data register go into the transmit queue, and the engine takes them from there. Each queue holds `DEPTH` entries, 16 by default.

A status register gives the fill state of both queues. A configuration register turns each queue's buffering on or off and sets the receive threshold. That threshold can only raise the trigger point above half the depth. The receive "almost" flag is sticky, and it is also the receive interrupt request. Software clears it by writing a one to its status bit.

The engine-side interface is a push strobe with data and error bits for receive, and a pop strobe with the head byte and a valid flag for transmit. Register reads return their value combinationally from the address. A read strobe at the data address pops the receive queue on the next clock edge.

Top module: `dual_byte_fifo`

## Requirements
- R1: After reset, status (address 2) reads 0x84, config (address 3) reads 0x88, rx_irq_o is 0 and tx_valid_o is 0.
- R2: Receive bytes leave in arrival order. With address 0, reg_rdata_o shows the head byte, and reg_rd_i pops it at the clock edge.
- R3: A pop of an empty queue and a push into a full queue are ignored. Data already queued is unaffected.
- R4: A register write to address 0 pushes the transmit queue. tx_byte_o shows the head, tx_valid_o is high while the queue is not empty, and tx_pop_i removes the head in write order.
- R5: Status bit positions are: bit 2 receive empty, bit 3 receive almost, bit 4 transmit full, bit 7 transmit almost. All other bits read 0.
- R6: Config bits 2:0 hold the threshold t. The almost flag sets one clock after the receive occupancy exceeds min(DEPTH/2 + t, DEPTH-1).
- R7: The almost flag stays set as the queue drains. A write to address 2 with bit 3 set clears it. A write with bit 3 clear has no effect on it.
- R8: rx_irq_o follows the receive almost flag.
- R9: Address 1 returns, in its low bits, the error bits stored with the most recently popped receive byte.
- R10: Config bit 3 enables receive buffering and bit 7 enables transmit buffering. With a bit cleared, that queue holds one entry.
- R11: The transmit almost bit is 1 whenever the transmit occupancy is DEPTH/2 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register select: 0 data, 1 error tag, 2 status, 3 config |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops receive at address 0) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| rx_push_i | input | 1 | Engine delivers a received byte |
| rx_byte_i | input | 8 | Received byte |
| rx_err_i | input | EW | Error bits for the received byte |
| tx_pop_i | input | 1 | Engine takes the transmit head |
| tx_byte_o | output | 8 | Transmit head byte |
| tx_valid_o | output | 1 | Transmit queue not empty |
| rx_irq_o | output | 1 | Receive interrupt request (almost flag) |

## Verification
The bench uses the default DEPTH of 16 and EW of 3. At that size both queues can be filled to the brim and run over within a few dozen cycles. Both ends of the threshold range are reached: threshold 0 trips at nine bytes, and threshold 7 hits the cap, so only a full queue trips it. Three error bits let each byte carry a distinct tag, so a tag that belongs to the wrong entry shows up.

// File: rtl/dual_byte_fifo_pkg.sv
package dual_byte_fifo_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_ERR  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CFG  = 2'd3;

  localparam int ST_RX_EMPTY  = 2;
  localparam int ST_RX_ALMOST = 3;
  localparam int ST_TX_FULL   = 4;
  localparam int ST_TX_ALMOST = 7;

  localparam int CF_RX_MODE = 3;
  localparam int CF_TX_MODE = 7;
  localparam int THR_W      = 3;

  localparam logic [7:0] CFG_MASK  = 8'h8F;
  localparam logic [7:0] CFG_RESET = 8'h88;
endpackage

// File: rtl/dbf_queue.sv
module dbf_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          single_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q, cap_w;
  logic          push_ok, pop_ok;

  assign cap_w   = single_i ? CW'(1) : CW'(DEPTH);
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q >= cap_w);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_empty_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> ($stable(cnt_q) && $stable(rp_q)));
  p_full_push_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> ($stable(cnt_q) && $stable(wp_q)));
endmodule

// File: rtl/dbf_almost.sv
module dbf_almost #(
  parameter int DEPTH = 16,
  parameter int TW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [TW-1:0] thr_i,
  input  logic          clr_i,
  output logic          flag_o
);
  logic [CW:0] sum_w, lim_w;
  logic        over_w, flag_q;

  // trigger point never below half depth, capped one under full
  assign sum_w  = (CW+1)'(DEPTH / 2) + (CW+1)'(thr_i);
  assign lim_w  = (sum_w > (CW+1)'(DEPTH - 1)) ? (CW+1)'(DEPTH - 1) : sum_w;
  assign over_w = ({1'b0, count_i} > lim_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;
    else if (over_w) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_w && !clr_i) |=> flag_o);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o);
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/dual_byte_fifo.sv
module dual_byte_fifo
  import dual_byte_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int EW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          rx_push_i,
  input  logic [7:0]    rx_byte_i,
  input  logic [EW-1:0] rx_err_i,
  input  logic          tx_pop_i,
  output logic [7:0]    tx_byte_o,
  output logic          tx_valid_o,
  output logic          rx_irq_o
);
  logic [7:0]      cfg_q, stat_w;
  logic [EW-1:0]   err_q;
  logic [EW+7:0]   rx_head;
  logic [CW-1:0]   rx_cnt, tx_cnt;
  logic            rx_empty, rx_full, tx_empty, tx_full;
  logic            rx_pop, tx_push, almost_clr, rx_almost;

  assign rx_pop     = reg_rd_i && (reg_addr_i == ADDR_DATA);
  assign tx_push    = reg_wr_i && (reg_addr_i == ADDR_DATA);
  assign almost_clr = reg_wr_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[ST_RX_ALMOST];

  dbf_queue #(.W(EW + 8), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .single_i (!cfg_q[CF_RX_MODE]),
    .push_i   (rx_push_i),
    .din_i    ({rx_err_i, rx_byte_i}),
    .pop_i    (rx_pop),
    .dout_o   (rx_head),
    .count_o  (rx_cnt),
    .empty_o  (rx_empty),
    .full_o   (rx_full)
  );

  dbf_queue #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .single_i (!cfg_q[CF_TX_MODE]),
    .push_i   (tx_push),
    .din_i    (reg_wdata_i),
    .pop_i    (tx_pop_i),
    .dout_o   (tx_byte_o),
    .count_o  (tx_cnt),
    .empty_o  (tx_empty),
    .full_o   (tx_full)
  );

  dbf_almost #(.DEPTH(DEPTH), .TW(THR_W)) u_almost (
    .clk_i, .rst_ni,
    .count_i (rx_cnt),
    .thr_i   (cfg_q[THR_W-1:0]),
    .clr_i   (almost_clr),
    .flag_o  (rx_almost)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RESET;
      err_q <= '0;
    end else begin
      if (reg_wr_i && reg_addr_i == ADDR_CFG) cfg_q <= reg_wdata_i & CFG_MASK;
      if (rx_pop && !rx_empty) err_q <= rx_head[EW+7:8];
    end
  end

  always_comb begin
    stat_w               = '0;
    stat_w[ST_RX_EMPTY]  = rx_empty;
    stat_w[ST_RX_ALMOST] = rx_almost;
    stat_w[ST_TX_FULL]   = tx_full;
    stat_w[ST_TX_ALMOST] = (tx_cnt <= CW'(DEPTH / 2));
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_DATA: reg_rdata_o = rx_head[7:0];
      ADDR_ERR:  reg_rdata_o = 8'(err_q);
      ADDR_STAT: reg_rdata_o = stat_w;
      default:   reg_rdata_o = cfg_q;
    endcase
  end

  assign tx_valid_o = !tx_empty;
  assign rx_irq_o   = rx_almost;

  p_err_tag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop && !rx_empty) |=> (err_q == $past(rx_head[EW+7:8])));
  p_tx_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push && !tx_full && !tx_pop_i) |=> tx_valid_o);
  p_rx_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q[CF_RX_MODE] && !rx_full) |-> (rx_cnt == '0));
endmodule

// File: tb/sim_dual_byte_fifo.sv
module sim_dual_byte_fifo;
  localparam int DEPTH = 16;
  localparam int EW    = 3;

  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr = 0, rd = 0, rx_push = 0, tx_pop = 0;
  logic [7:0] wdata = 0, rx_byte = 0;
  logic [EW-1:0] rx_err = 0;
  logic [7:0] rdata, tx_byte;
  logic tx_valid, irq;
  int total = 0, bad = 0;
  logic [EW+7:0] rx_q[$];
  logic [7:0]    tx_q[$];

  always #4 clk = ~clk;

  dual_byte_fifo #(.DEPTH(DEPTH), .EW(EW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rx_push_i(rx_push), .rx_byte_i(rx_byte),
    .rx_err_i(rx_err), .tx_pop_i(tx_pop), .tx_byte_o(tx_byte), .tx_valid_o(tx_valid),
    .rx_irq_o(irq));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  // driver: engine delivers a byte; scoreboard records it if room
  task automatic rx_put(input logic [7:0] b, input logic [EW-1:0] e, input bit keep);
    @(negedge clk); rx_byte = b; rx_err = e; rx_push = 1;
    if (keep) rx_q.push_back({e, b});
    @(negedge clk); rx_push = 0;
  endtask

  // monitor: pop a byte via register port, compare data then tag
  task automatic rx_take(input string req);
    logic [EW+7:0] exp;
    exp = rx_q.pop_front();
    @(negedge clk); addr = 2'd0; #1 chk(rdata, exp[7:0], req);
    rd = 1;
    @(negedge clk); rd = 0; addr = 2'd1; #1 chk(rdata, 8'(exp[EW+7:8]), "R9");
  endtask

  task automatic tx_put(input logic [7:0] b, input bit keep);
    if (keep) tx_q.push_back(b);
    wr_reg(2'd0, b);
  endtask

  task automatic tx_take(input string req);
    logic [7:0] exp;
    exp = tx_q.pop_front();
    @(negedge clk); #1 chk({7'b0, tx_valid}, 8'h01, req); chk(tx_byte, exp, req);
    tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_reg(2'd2, v); chk(v, 8'h84, "R1");
    rd_reg(2'd3, v); chk(v, 8'h88, "R1");
    chk({6'b0, irq, tx_valid}, 8'h00, "R1");

    // R2 / R9 ordering and tags
    rx_put(8'h11, 3'd1, 1); rx_put(8'h22, 3'd6, 1); rx_put(8'h33, 3'd4, 1);
    rd_reg(2'd2, v); chk(v, 8'h80, "R5");
    for (int i = 0; i < 3; i++) rx_take("R2");
    rd_reg(2'd2, v); chk(v, 8'h84, "R5");

    // R3 pop of empty ignored
    @(negedge clk); addr = 2'd0; rd = 1; @(negedge clk); rd = 0;
    rd_reg(2'd1, v); chk(v, 8'h04, "R3");
    rx_put(8'hA5, 3'd2, 1); rx_take("R3");
    rd_reg(2'd2, v); chk(v, 8'h84, "R3");

    // R6 threshold 0: nine bytes trips
    for (int i = 0; i < 8; i++) rx_put(8'(8'h40 + i), 3'(i), 1);
    repeat (2) @(negedge clk); chk({7'b0, irq}, 8'h00, "R6");
    rx_put(8'h48, 3'd5, 1);
    repeat (2) @(negedge clk); chk({7'b0, irq}, 8'h01, "R8");
    rd_reg(2'd2, v); chk(v, 8'h88, "R5");
    // R7 sticky, write-0 no effect, write-1 clears
    rx_take("R2"); rx_take("R2");
    chk({7'b0, irq}, 8'h01, "R7");
    wr_reg(2'd2, 8'hF7); @(negedge clk); chk({7'b0, irq}, 8'h01, "R7");
    wr_reg(2'd2, 8'h08); @(negedge clk); chk({7'b0, irq}, 8'h00, "R7");
    while (rx_q.size() > 0) rx_take("R2");

    // R6 threshold 7 caps at DEPTH-1
    wr_reg(2'd3, 8'hFF); rd_reg(2'd3, v); chk(v, 8'h8F, "R6");
    for (int i = 0; i < 15; i++) rx_put(8'(8'h60 + i), 3'(i), 1);
    repeat (2) @(negedge clk); chk({7'b0, irq}, 8'h00, "R6");
    rx_put(8'h7F, 3'd7, 1);
    repeat (2) @(negedge clk); chk({7'b0, irq}, 8'h01, "R6");
    rx_put(8'hEE, 3'd3, 0);  // R3 push when full ignored
    while (rx_q.size() > 0) rx_take("R3");
    rd_reg(2'd2, v); chk(v, 8'h8C, "R3");
    wr_reg(2'd2, 8'h08);

    // R4 / R11 transmit
    for (int i = 0; i < DEPTH; i++) tx_put(8'(8'hC0 + i), 1);
    rd_reg(2'd2, v); chk(v, 8'h14, "R4");
    tx_put(8'hDD, 0);  // ignored
    for (int i = 0; i < 7; i++) tx_take("R4");
    rd_reg(2'd2, v); chk(v, 8'h04, "R11");
    tx_take("R4");
    rd_reg(2'd2, v); chk(v, 8'h84, "R11");
    while (tx_q.size() > 0) tx_take("R4");
    @(negedge clk); chk({7'b0, tx_valid}, 8'h00, "R4");

    // R10 buffering disabled: one entry each
    wr_reg(2'd3, 8'h00);
    tx_put(8'h5A, 1);
    rd_reg(2'd2, v); chk(v, 8'h94, "R10");
    tx_put(8'h5B, 0);
    tx_take("R10");
    @(negedge clk); chk({7'b0, tx_valid}, 8'h00, "R10");
    rx_put(8'h9A, 3'd1, 1); rx_put(8'h9B, 3'd2, 0);
    rx_take("R10");
    rd_reg(2'd2, v); chk(v, 8'h84, "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule